// File: doc/BRIEF.md
# Serial Audio Controller Command and Interrupt Register Bank

This block is the register front end of a multi-channel serial audio controller. A 32-bit word-wide register port with a 4-byte stride lets software start and stop the receiver, the transmitter and the bit clock. It also holds two mode words for the datapath and services two interrupt groups that share one interrupt line. The audio datapath and the clock generators sit outside. They take the enable flags and mode words from this block, and they return per-channel ready, underrun and overflow events and FIFO flags on dedicated inputs.

Control is written as pulses. Each enable has its own write-one "on" and "off" bit in a write-only command word, and a reset bit in the same word returns the configuration to zero. Interrupt masks work the same way: software writes ones to a set register or a clear register and reads the result from a mask register. Level-type sources (ready, FIFO flags) follow their inputs. Edge-type sources (underrun, overflow, write error) are held until software reads their group's status word.

Top module: `aud_regbank`

## Requirements
- R1: Mode word A (offset 0x04) and mode word B (offset 0x08) are read/write. A written value drives `mode_a`/`mode_b` from the clock edge that takes the write, and reads back unchanged.
- R2: The command word at 0x00 is write-one. Bit 0 turns the receiver on and bit 1 turns it off. Bit 2 turns the clock on and bit 3 turns it off. Bit 4 turns the transmitter on and bit 5 turns it off. Zero bits leave a flag alone, and when both bits of a pair are one the flag ends off.
- R3: Bit 7 of the command word clears both mode words, both interrupt masks and all three enable flags at the edge of the write, and it overrides every other bit written with it.
- R4: The status word at 0x0C reads the receiver flag in bit 0 and the transmitter flag in bit 4. All other bits read zero.
- R5: In interrupt group A, channel c uses bit c for transmit ready, bit 8+c for transmit underrun, bit 16+c for receive ready and bit 24+c for receive overflow. Ready bits follow their input one register later. Underrun and overflow bits are held once set. Bits of channels at or above NCH read zero.
- R6: In interrupt group B, bit 0 is write error (held), bit 8 is transmit FIFO ready, bit 9 is transmit FIFO empty, bit 12 is receive FIFO ready and bit 13 is receive FIFO full (all four follow their input). All other bits read zero.
- R7: Writing ones to 0x10 (group A) or 0x20 (group B) sets mask bits. Writing ones to 0x14 or 0x24 clears them. Zero bits have no effect. The masks read at 0x18 and 0x28, and a mask bit with no source behind it stays zero.
- R8: `irq` is high when any bit of either group has both its status bit and its mask bit set. It is registered, so it rises one cycle after the status or the mask that causes it.
- R9: Reading group A status (0x1C) or group B status (0x2C) returns the current word and clears that group's held bits. An event arriving in the same cycle as the read is kept for the next read.
- R10: Offset 0xFC reads the VERSION parameter in bits 11:0 and zeros above.
- R11: The command word, the set/clear registers and every unmapped offset read zero. Writes to the status, mask and version offsets change nothing.
- R12: Every read returns its data with `bus_rvalid` high one cycle after the request. Writes raise no `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| ev_tx_rdy | input | NCH | Per-channel transmit ready (level) |
| ev_tx_unf | input | NCH | Per-channel transmit underrun (pulse) |
| ev_rx_rdy | input | NCH | Per-channel receive ready (level) |
| ev_rx_ovf | input | NCH | Per-channel receive overflow (pulse) |
| ev_wr_err | input | 1 | Write error (pulse) |
| ev_txff_rdy | input | 1 | Transmit FIFO ready (level) |
| ev_txff_empty | input | 1 | Transmit FIFO empty (level) |
| ev_rxff_rdy | input | 1 | Receive FIFO ready (level) |
| ev_rxff_full | input | 1 | Receive FIFO full (level) |
| rx_on | output | 1 | Receiver enabled |
| tx_on | output | 1 | Transmitter enabled |
| clk_on | output | 1 | Serial clock enabled |
| mode_a | output | 32 | Mode word A to the datapath |
| mode_b | output | 32 | Mode word B to the datapath |
| irq | output | 1 | Interrupt request |

## Verification
Enable flags, mode words and masks change at the edge that takes the write, so the bench checks them at the falling edge that follows. Read data and `bus_rvalid` appear one edge after the request and are sampled at the falling edge where the request is withdrawn. An event input shows in status one edge after it is applied, and `irq` follows one edge after that. After a mask write, `irq` changes one edge later. The bench therefore waits exactly those edges before each interrupt check, and it reads status twice to see held bits clear.

// File: rtl/aud_reg_pkg.sv
package aud_reg_pkg;

    localparam int LANE = 8;

    localparam logic [7:0] OFS_CMD   = 8'h00;
    localparam logic [7:0] OFS_MODEA = 8'h04;
    localparam logic [7:0] OFS_MODEB = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0C;
    localparam logic [7:0] OFS_A_SET = 8'h10;
    localparam logic [7:0] OFS_A_CLR = 8'h14;
    localparam logic [7:0] OFS_A_MSK = 8'h18;
    localparam logic [7:0] OFS_A_STS = 8'h1C;
    localparam logic [7:0] OFS_B_SET = 8'h20;
    localparam logic [7:0] OFS_B_CLR = 8'h24;
    localparam logic [7:0] OFS_B_MSK = 8'h28;
    localparam logic [7:0] OFS_B_STS = 8'h2C;
    localparam logic [7:0] OFS_VER   = 8'hFC;

    localparam int CB_RX_ON  = 0;
    localparam int CB_RX_OFF = 1;
    localparam int CB_CK_ON  = 2;
    localparam int CB_CK_OFF = 3;
    localparam int CB_TX_ON  = 4;
    localparam int CB_TX_OFF = 5;
    localparam int CB_RESET  = 7;

    localparam int SB_RX = 0;
    localparam int SB_TX = 4;

    localparam int GB_WERR  = 0;
    localparam int GB_TXFR  = 8;
    localparam int GB_TXFE  = 9;
    localparam int GB_RXFR  = 12;
    localparam int GB_RXFF  = 13;

    localparam logic [31:0] GRPB_VALID  = 32'h0000_3301;
    localparam logic [31:0] GRPB_STICKY = 32'h0000_0001;

    // Lanes of group A: 0 tx ready, 1 tx underrun, 2 rx ready, 3 rx overflow
    function automatic logic [31:0] grpa_valid(int nch);
        logic [31:0] v = '0;
        for (int l = 0; l < 4; l++)
            for (int c = 0; c < nch; c++)
                v[l*LANE + c] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] grpa_sticky(int nch);
        logic [31:0] v = '0;
        for (int c = 0; c < nch; c++) begin
            v[1*LANE + c] = 1'b1;
            v[3*LANE + c] = 1'b1;
        end
        return v;
    endfunction

    typedef struct packed {
        logic        rx;
        logic        ck;
        logic        tx;
        logic [31:0] mode_a;
        logic [31:0] mode_b;
    } ctl_t;

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] held;
        logic [31:0] level;
    } grp_t;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
        logic        irq;
    } rsp_t;

endpackage

// File: rtl/aud_cmd_ctrl.sv
module aud_cmd_ctrl
    import aud_reg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic        modea_we,
    input  logic        modeb_we,
    input  logic [31:0] wdata,
    output logic        sw_rst,
    output logic        rx_on,
    output logic        ck_on,
    output logic        tx_on,
    output logic [31:0] mode_a,
    output logic [31:0] mode_b
);

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (modea_we) st_d.mode_a = wdata;
        if (modeb_we) st_d.mode_b = wdata;
        if (cmd_we) begin
            // "off" is applied after "on" so it wins within a pair
            if (wdata[CB_RX_ON])  st_d.rx = 1'b1;
            if (wdata[CB_RX_OFF]) st_d.rx = 1'b0;
            if (wdata[CB_CK_ON])  st_d.ck = 1'b1;
            if (wdata[CB_CK_OFF]) st_d.ck = 1'b0;
            if (wdata[CB_TX_ON])  st_d.tx = 1'b1;
            if (wdata[CB_TX_OFF]) st_d.tx = 1'b0;
            if (wdata[CB_RESET])  st_d    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw_rst = cmd_we & wdata[CB_RESET];
    assign rx_on  = st_q.rx;
    assign ck_on  = st_q.ck;
    assign tx_on  = st_q.tx;
    assign mode_a = st_q.mode_a;
    assign mode_b = st_q.mode_b;

endmodule

// File: rtl/aud_irq_group.sv
module aud_irq_group
    import aud_reg_pkg::*;
#(
    parameter logic [31:0] VALID  = 32'hFFFF_FFFF,
    parameter logic [31:0] STICKY = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_rst,
    input  logic [31:0] ev,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic        stat_rd,
    input  logic [31:0] wdata,
    output logic [31:0] mask,
    output logic [31:0] stat,
    output logic        pend
);

    localparam logic [31:0] LEVEL = VALID & ~STICKY;
    localparam logic [31:0] HELD  = VALID & STICKY;

    grp_t g_d, g_q;

    always_comb begin
        g_d       = g_q;
        g_d.level = ev & LEVEL;
        // a read clears held bits; a new event in the same cycle survives
        g_d.held  = (stat_rd ? '0 : g_q.held) | (ev & HELD);
        if (set_we) g_d.mask = g_q.mask | (wdata & VALID);
        if (clr_we) g_d.mask = g_q.mask & ~wdata;
        if (sw_rst) g_d.mask = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign mask = g_q.mask;
    assign stat = g_q.level | g_q.held;
    assign pend = |(stat & g_q.mask);

endmodule

// File: rtl/aud_regbank.sv
module aud_regbank
    import aud_reg_pkg::*;
#(
    parameter int          NCH     = 8,
    parameter logic [11:0] VERSION = 12'h3A7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           bus_rvalid,
    input  logic [NCH-1:0] ev_tx_rdy,
    input  logic [NCH-1:0] ev_tx_unf,
    input  logic [NCH-1:0] ev_rx_rdy,
    input  logic [NCH-1:0] ev_rx_ovf,
    input  logic           ev_wr_err,
    input  logic           ev_txff_rdy,
    input  logic           ev_txff_empty,
    input  logic           ev_rxff_rdy,
    input  logic           ev_rxff_full,
    output logic           rx_on,
    output logic           tx_on,
    output logic           clk_on,
    output logic [31:0]    mode_a,
    output logic [31:0]    mode_b,
    output logic           irq
);

    localparam logic [31:0] A_VALID  = grpa_valid(NCH);
    localparam logic [31:0] A_STICKY = grpa_sticky(NCH);

    logic wr, rd;
    assign wr = bus_sel &  bus_wr;
    assign rd = bus_sel & ~bus_wr;

    // group A event packing, one 8-bit lane per source kind
    logic [31:0] ev_a, ev_b;
    for (genvar c = 0; c < LANE; c++) begin : g_lane
        if (c < NCH) begin : g_used
            assign ev_a[0*LANE + c] = ev_tx_rdy[c];
            assign ev_a[1*LANE + c] = ev_tx_unf[c];
            assign ev_a[2*LANE + c] = ev_rx_rdy[c];
            assign ev_a[3*LANE + c] = ev_rx_ovf[c];
        end else begin : g_free
            assign ev_a[0*LANE + c] = 1'b0;
            assign ev_a[1*LANE + c] = 1'b0;
            assign ev_a[2*LANE + c] = 1'b0;
            assign ev_a[3*LANE + c] = 1'b0;
        end
    end

    always_comb begin
        ev_b          = '0;
        ev_b[GB_WERR] = ev_wr_err;
        ev_b[GB_TXFR] = ev_txff_rdy;
        ev_b[GB_TXFE] = ev_txff_empty;
        ev_b[GB_RXFR] = ev_rxff_rdy;
        ev_b[GB_RXFF] = ev_rxff_full;
    end

    logic sw_rst;

    aud_cmd_ctrl u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (wr && bus_addr == OFS_CMD),
        .modea_we (wr && bus_addr == OFS_MODEA),
        .modeb_we (wr && bus_addr == OFS_MODEB),
        .wdata    (bus_wdata),
        .sw_rst   (sw_rst),
        .rx_on    (rx_on),
        .ck_on    (clk_on),
        .tx_on    (tx_on),
        .mode_a   (mode_a),
        .mode_b   (mode_b)
    );

    logic [31:0] mask_a, stat_a, mask_b, stat_b;
    logic        pend_a, pend_b;

    aud_irq_group #(.VALID(A_VALID), .STICKY(A_STICKY)) u_grp_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_rst  (sw_rst),
        .ev      (ev_a),
        .set_we  (wr && bus_addr == OFS_A_SET),
        .clr_we  (wr && bus_addr == OFS_A_CLR),
        .stat_rd (rd && bus_addr == OFS_A_STS),
        .wdata   (bus_wdata),
        .mask    (mask_a),
        .stat    (stat_a),
        .pend    (pend_a)
    );

    aud_irq_group #(.VALID(GRPB_VALID), .STICKY(GRPB_STICKY)) u_grp_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_rst  (sw_rst),
        .ev      (ev_b),
        .set_we  (wr && bus_addr == OFS_B_SET),
        .clr_we  (wr && bus_addr == OFS_B_CLR),
        .stat_rd (rd && bus_addr == OFS_B_STS),
        .wdata   (bus_wdata),
        .mask    (mask_b),
        .stat    (stat_b),
        .pend    (pend_b)
    );

    rsp_t r_d, r_q;
    logic [31:0] rmux;

    always_comb begin
        rmux = '0;
        case (bus_addr)
            OFS_MODEA: rmux = mode_a;
            OFS_MODEB: rmux = mode_b;
            OFS_STAT: begin
                rmux[SB_RX] = rx_on;
                rmux[SB_TX] = tx_on;
            end
            OFS_A_MSK: rmux = mask_a;
            OFS_A_STS: rmux = stat_a;
            OFS_B_MSK: rmux = mask_b;
            OFS_B_STS: rmux = stat_b;
            OFS_VER:   rmux = {20'd0, VERSION};
            default:   rmux = '0;
        endcase
    end

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = rd;
        r_d.rdata  = rd ? rmux : '0;
        r_d.irq    = pend_a | pend_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata  = r_q.rdata;
    assign bus_rvalid = r_q.rvalid;
    assign irq        = r_q.irq;

endmodule

// File: rtl/aud_regbank_chk.sv
module aud_regbank_chk #(
    parameter logic [11:0] VERSION = 12'h3A7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_rvalid,
    input logic        rx_on,
    input logic        tx_on,
    input logic        clk_on,
    input logic [31:0] mode_a,
    input logic [31:0] mode_b,
    input logic        irq
);

    logic rd, wr;
    assign rd = bus_sel && !bus_wr;
    assign wr = bus_sel &&  bus_wr;

    a_r1_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h04) |=> (mode_a == $past(bus_wdata)));

    a_r2_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h00 && bus_wdata[0] && bus_wdata[1]) |=> !rx_on);

    a_r3_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h00 && bus_wdata[7]) |=>
        (mode_a == 32'd0 && mode_b == 32'd0 && !rx_on && !tx_on && !clk_on));

    a_r3_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h00 && bus_wdata[7]) |=> ##1 !irq);

    a_r4_status_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == 8'h0C) |=>
        (bus_rdata[0] == rx_on && bus_rdata[4] == tx_on &&
         bus_rdata[3:1] == 3'd0 && bus_rdata[31:5] == 27'd0));

    a_r10_version: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == 8'hFC) |=> (bus_rdata == {20'd0, VERSION}));

    a_r11_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (bus_addr == 8'h00 || bus_addr == 8'h10 || bus_addr == 8'h14 ||
                bus_addr == 8'h20 || bus_addr == 8'h24)) |=> (bus_rdata == 32'd0));

    a_r12_rvalid_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);

    a_r12_rvalid_write: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !bus_rvalid);

endmodule

bind aud_regbank aud_regbank_chk #(.VERSION(VERSION)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .rx_on      (rx_on),
    .tx_on      (tx_on),
    .clk_on     (clk_on),
    .mode_a     (mode_a),
    .mode_b     (mode_b),
    .irq        (irq)
);

// File: tb/tb_aud_regbank.sv
`timescale 1ns/1ps
module tb_aud_regbank;

    localparam int          NCH = 8;
    localparam logic [11:0] VER = 12'h3A7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           bus_rvalid;
    logic [NCH-1:0] ev_tx_rdy = '0, ev_tx_unf = '0, ev_rx_rdy = '0, ev_rx_ovf = '0;
    logic           ev_wr_err = 1'b0, ev_txff_rdy = 1'b0, ev_txff_empty = 1'b0;
    logic           ev_rxff_rdy = 1'b0, ev_rxff_full = 1'b0;
    logic           rx_on, tx_on, clk_on, irq;
    logic [31:0]    mode_a, mode_b;

    always #2 clk = ~clk;

    aud_regbank #(.NCH(NCH), .VERSION(VER)) dut (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one access; returns with read data registered, sampled at falling edge
    task automatic acc(bit w, logic [7:0] a, logic [31:0] d, output logic [31:0] rdat);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        rdat = bus_rdata;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    typedef struct packed {
        logic        w;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'h04, 32'hA5A5_1234, 32'h0,         8'd1 },  // R1
        '{1'b0, 8'h04, 32'h0,         32'hA5A5_1234, 8'd1 },
        '{1'b1, 8'h08, 32'h0000_0311, 32'h0,         8'd1 },
        '{1'b0, 8'h08, 32'h0,         32'h0000_0311, 8'd1 },
        '{1'b1, 8'h00, 32'h0000_0011, 32'h0,         8'd4 },  // R4 rx+tx on
        '{1'b0, 8'h0C, 32'h0,         32'h0000_0011, 8'd4 },
        '{1'b1, 8'h00, 32'h0000_0003, 32'h0,         8'd2 },  // R2 pair: off wins
        '{1'b0, 8'h0C, 32'h0,         32'h0000_0010, 8'd2 },
        '{1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0,         8'd11},  // R11 read-only write
        '{1'b0, 8'h0C, 32'h0,         32'h0000_0010, 8'd11},
        '{1'b1, 8'h10, 32'h0101_0101, 32'h0,         8'd7 },  // R7 set
        '{1'b0, 8'h18, 32'h0,         32'h0101_0101, 8'd7 },
        '{1'b1, 8'h14, 32'h0000_0001, 32'h0,         8'd7 },  // R7 clear
        '{1'b0, 8'h18, 32'h0,         32'h0101_0100, 8'd7 },
        '{1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0,         8'd7 },
        '{1'b0, 8'h28, 32'h0,         32'h0000_3301, 8'd7 },
        '{1'b0, 8'h00, 32'h0,         32'h0,         8'd11},
        '{1'b0, 8'h10, 32'h0,         32'h0,         8'd11},
        '{1'b0, 8'h40, 32'h0,         32'h0,         8'd11},
        '{1'b0, 8'hFC, 32'h0,         {20'd0, VER},  8'd10},  // R10
        '{1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0,         8'd11},
        '{1'b0, 8'h18, 32'h0,         32'h0101_0100, 8'd11},
        '{1'b1, 8'h00, 32'h0000_0080, 32'h0,         8'd3 },  // R3 reset strobe
        '{1'b0, 8'h04, 32'h0,         32'h0,         8'd3 },
        '{1'b0, 8'h18, 32'h0,         32'h0,         8'd3 },
        '{1'b0, 8'h28, 32'h0,         32'h0,         8'd3 },
        '{1'b0, 8'h0C, 32'h0,         32'h0,         8'd3 }
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // reset state
        chk("R12 reset rvalid", {31'd0, bus_rvalid}, 32'd0);
        chk("R8 reset irq", {31'd0, irq}, 32'd0);
        chk("R3 reset flags", {29'd0, rx_on, tx_on, clk_on}, 32'd0);
        chk("R1 reset mode_a", mode_a, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // vector table
        for (int i = 0; i < NV; i++) begin
            acc(TBL[i].w, TBL[i].a, TBL[i].d, r);
            if (!TBL[i].w) begin
                chk($sformatf("R%0d vec %0d", TBL[i].req, i), r, TBL[i].e);
                chk("R12 rvalid", {31'd0, bus_rvalid}, 32'd1);
            end
        end

        // R2 clock pair
        acc(1'b1, 8'h00, 32'h4, r);
        chk("R2 clk on", {31'd0, clk_on}, 32'd1);
        acc(1'b1, 8'h00, 32'h8, r);
        chk("R2 clk off", {31'd0, clk_on}, 32'd0);
        acc(1'b1, 8'h00, 32'h10, r);
        acc(1'b1, 8'h00, 32'h0, r);
        chk("R2 zero bits keep tx", {31'd0, tx_on}, 32'd1);
        // R3 reset beats enables written with it
        acc(1'b1, 8'h00, 32'h95, r);
        chk("R3 reset wins", {29'd0, rx_on, tx_on, clk_on}, 32'd0);

        // R5 level bits and R8 irq timing
        @(negedge clk); ev_tx_rdy[3] = 1'b1; ev_rx_rdy[5] = 1'b1;
        acc(1'b0, 8'h1C, 32'h0, r);
        chk("R5 ready bits", r, 32'h0020_0008);
        chk("R8 unmasked no irq", {31'd0, irq}, 32'd0);
        acc(1'b1, 8'h10, 32'h0000_0008, r);
        @(negedge clk);
        chk("R8 irq after mask", {31'd0, irq}, 32'd1);
        ev_tx_rdy[3] = 1'b0;
        @(negedge clk);
        chk("R8 irq lags status", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R8 irq drops", {31'd0, irq}, 32'd0);
        ev_rx_rdy[5] = 1'b0;

        // R5 held underrun/overflow, R9 clear on read
        @(negedge clk); ev_tx_unf[2] = 1'b1; ev_rx_ovf[7] = 1'b1;
        @(negedge clk); ev_tx_unf = '0; ev_rx_ovf = '0;
        acc(1'b0, 8'h1C, 32'h0, r);
        chk("R5 held bits", r, 32'h8000_0400);
        acc(1'b0, 8'h1C, 32'h0, r);
        chk("R9 cleared by read", r, 32'h0);

        // R9 event in the same cycle as the read is kept
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h1C; ev_rx_ovf[0] = 1'b1;
        @(negedge clk);
        r = bus_rdata; bus_sel = 1'b0; bus_addr = '0; ev_rx_ovf[0] = 1'b0;
        chk("R9 same-cycle read", r, 32'h0);
        acc(1'b0, 8'h1C, 32'h0, r);
        chk("R9 same-cycle kept", r, 32'h0100_0000);

        // R6 group B and R8 from group B
        acc(1'b1, 8'h14, 32'hFFFF_FFFF, r);
        @(negedge clk); ev_wr_err = 1'b1; ev_txff_empty = 1'b1;
        @(negedge clk); ev_wr_err = 1'b0;
        acc(1'b0, 8'h2C, 32'h0, r);
        chk("R6 group B status", r, 32'h0000_0201);
        acc(1'b0, 8'h2C, 32'h0, r);
        chk("R6 level stays, held clears", r, 32'h0000_0200);
        chk("R8 no mask no irq", {31'd0, irq}, 32'd0);
        acc(1'b1, 8'h20, 32'h0000_0200, r);
        @(negedge clk);
        chk("R8 group B irq", {31'd0, irq}, 32'd1);
        acc(1'b1, 8'h24, 32'h0000_0200, r);
        @(negedge clk);
        chk("R7 clear drops irq", {31'd0, irq}, 32'd0);
        ev_txff_empty = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule